// File: doc/BRIEF.md
# Rate-Coded Spike Encoder

The encoder turns a frame of pixel intensities into a train of one-bit spike vectors for the input layer of a spiking network. Pixels arrive one per valid beat and are stored in arrival order. Once the last pixel of the frame is taken, the encoder replays the stored frame for a programmable number of time steps. It emits one spike vector per clock, with one bit per pixel.

The coding is deterministic. Each pixel owns a phase accumulator. On every step the pixel's intensity is added to its accumulator. When the sum wraps past the accumulator range, the pixel fires and the wrapped remainder is kept. The firing rate therefore tracks intensity: a dark pixel never fires, a mid-grey pixel fires on every second step, and a full-scale pixel fires on every step. A flag marks the last vector of each window. Loading of the next frame may begin in the clock that follows that vector.

Top module: `rate_spike_encoder`

## Requirements
- R1: While reset is held and on the first cycle after it, `spk_valid`, `frame_done` and `spk_vec` are all zero.
- R2: Pixels are stored in the order of accepted `pix_valid` beats. Idle cycles between beats are allowed. Bit i of `spk_vec` belongs to the i-th pixel accepted in the frame (i counts from 0).
- R3: Suppose the NPIX-th pixel is accepted at a clock edge and the step count is N. Then `spk_valid` is high for exactly N consecutive cycles, starting on the cycle after that edge. Whenever `spk_valid` is low, `spk_vec` is zero.
- R4: Each pixel's 8-bit accumulator starts at zero for every frame. On step s, the accumulator adds the intensity. The bit fires when the sum reaches 256, and the accumulator then keeps the sum minus 256. Intensity 0 never fires.
- R5: Intensity 128 fires on the even-numbered steps (2, 4, 6, ...) and stays silent on the odd-numbered steps.
- R6: Intensity 255 fires on every step of the window.
- R7: `frame_done` is high only in the cycle that carries the last spike vector of a window.
- R8: `pix_valid` beats that arrive while a window is being emitted are discarded. They change neither the stored frame nor the load position.
- R9: A step count of zero produces no spike vectors and no `frame_done`. The encoder is then ready for the next frame at once.
- R10: `num_steps` is sampled on the edge that accepts the last pixel. Changes to it during the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid | input | 1 | Pixel beat qualifier |
| pix_data | input | 8 | Pixel intensity, unsigned fraction of 256 |
| num_steps | input | STEP_W | Window length in time steps |
| spk_valid | output | 1 | Spike vector valid |
| spk_vec | output | NPIX | One spike bit per pixel |
| frame_done | output | 1 | Marks the last vector of the window |

## Verification
Counting from the edge that accepts the last pixel, step k's vector appears k cycles later (k = 1..N). `frame_done` comes with step N. The next pixel can be accepted at edge N+1. The bench drives inputs just after each rising edge and samples on the falling edge. It walks a per-cycle index from the last-pixel edge, so each cycle's expected `spk_valid` is known. A scoreboard queue, filled from an independent accumulator model before the frame is loaded, supplies the vector and done flag that each valid cycle must show.

// File: rtl/rc_pkg.sv
// Shared types and constants for the rate-coded spike encoder.
package rc_pkg;
    localparam int PIX_W = 8;
    typedef logic [PIX_W-1:0] pix_t;
    localparam pix_t PIX_FULL = '1;
endpackage

// File: rtl/rc_frame_loader.sv
// Collects NPIX pixels in arrival order and pulses frame_start on the last one.
// Assumes NPIX >= 2; beats seen while busy is high are dropped.
module rc_frame_loader
    import rc_pkg::*;
#(
    parameter int NPIX = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pix_valid,
    input  pix_t                       pix_data,
    input  logic                       busy,
    output logic [NPIX-1:0][PIX_W-1:0] inten_q,
    output logic                       frame_start
);
    localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NPIX - 1);

    logic [IDX_W-1:0] idx_q;
    logic             take;

    // Accept a beat only outside a window; flag the frame's final pixel.
    always_comb begin
        take        = pix_valid && !busy;
        frame_start = take && (idx_q == IDX_LAST);
    end

    // Store the pixel at the current position and advance the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            inten_q <= '0;
        end else if (take) begin
            inten_q[idx_q] <= pix_data;
            idx_q          <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end

    // R8: a busy cycle leaves the load state untouched
    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(idx_q) && $stable(inten_q)));
    // R2: position never leaves the frame
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_LAST);
endmodule

// File: rtl/rc_step_seq.sv
// Counts the time steps of one window and marks the final one.
// Assumes frame_start never arrives while running (loader is gated by it).
module rc_step_seq #(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [STEP_W-1:0] num_steps,
    output logic              running,
    output logic              last_step
);
    logic [STEP_W-1:0] cnt_q;
    logic [STEP_W-1:0] steps_q;

    // The final step is the one whose count equals the window length minus one.
    always_comb last_step = running && (cnt_q == steps_q - 1'b1);

    // Latch the window length at frame start and count steps while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt_q   <= '0;
            steps_q <= '0;
        end else if (frame_start) begin
            running <= (num_steps != '0);
            cnt_q   <= '0;
            steps_q <= num_steps;
        end else if (running) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_step) running <= 1'b0;
        end
    end

    // R3: the step count stays inside the window
    a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q < steps_q));
    // R9: a zero-length window never starts
    a_r9_zero_window: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && num_steps == '0) |=> !running);
    // R10: the window length is held for the whole window
    a_r10_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(steps_q));
endmodule

// File: rtl/rc_phase_acc.sv
// Per-pixel phase accumulator: adds the intensity each step and fires on wrap.
// Full-scale intensity fires every step; the spike output is registered and
// is zero outside steps.
module rc_phase_acc
    import rc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step_en,
    input  pix_t inten,
    output logic spike_q
);
    pix_t           acc_q;
    logic [PIX_W:0] sum;
    logic           fire;

    // Next phase and wrap detection.
    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, inten};
        fire = (inten == PIX_FULL) || sum[PIX_W];
    end

    // Clear per frame, advance per step, keep the wrapped remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            spike_q <= 1'b0;
        end else if (clear) begin
            acc_q   <= '0;
            spike_q <= 1'b0;
        end else if (step_en) begin
            acc_q   <= sum[PIX_W-1:0];
            spike_q <= fire;
        end else begin
            spike_q <= 1'b0;
        end
    end

    // R6: full intensity fires on every step
    a_r6_full_every_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && inten == PIX_FULL) |=> spike_q);
    // R4: zero intensity never fires
    a_r4_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && inten == '0) |=> !spike_q);
endmodule

// File: rtl/rate_spike_encoder.sv
// Top of the rate-coded spike encoder: loader, step sequencer and one phase
// accumulator per pixel. Spike vectors appear one cycle after each step.
module rate_spike_encoder
    import rc_pkg::*;
#(
    parameter int NPIX   = 8,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [7:0]        pix_data,
    input  logic [STEP_W-1:0] num_steps,
    output logic              spk_valid,
    output logic [NPIX-1:0]   spk_vec,
    output logic              frame_done
);
    logic [NPIX-1:0][PIX_W-1:0] inten;
    logic                       frame_start;
    logic                       running;
    logic                       last_step;

    rc_frame_loader #(.NPIX(NPIX)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .busy       (running),
        .inten_q    (inten),
        .frame_start(frame_start)
    );

    rc_step_seq #(.STEP_W(STEP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .num_steps  (num_steps),
        .running    (running),
        .last_step  (last_step)
    );

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        rc_phase_acc u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (frame_start),
            .step_en(running),
            .inten  (inten[p]),
            .spike_q(spk_vec[p])
        );
    end

    // Register valid and done in step with the registered spike bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spk_valid  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            spk_valid  <= running;
            frame_done <= last_step;
        end
    end

    // R7: done only travels with a valid vector
    a_r7_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> spk_valid);
    // R3: no spike bits outside a window
    a_r3_vec_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !spk_valid |-> (spk_vec == '0));
endmodule

// File: tb/test_rate_spike_encoder.sv
`timescale 1ns/1ps
module test_rate_spike_encoder;
    localparam int NPIX   = 8;
    localparam int STEP_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pix_valid = 1'b0;
    logic [7:0]        pix_data = '0;
    logic [STEP_W-1:0] num_steps = '0;
    logic              spk_valid;
    logic [NPIX-1:0]   spk_vec;
    logic              frame_done;

    int checks = 0;
    int fails  = 0;
    logic [NPIX:0] sb_q[$];   // {done, vector}

    always #2 clk = ~clk;

    rate_spike_encoder #(.NPIX(NPIX), .STEP_W(STEP_W)) i_rate_spike_encoder (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .num_steps(num_steps), .spk_valid(spk_valid), .spk_vec(spk_vec),
        .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected vectors as the design emits them.
    always @(negedge clk) begin
        if (rst_n && spk_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3 unexpected vector", int'(spk_vec), 0);
            end else begin
                logic [NPIX:0] e;
                e = sb_q.pop_front();
                check(spk_vec == e[NPIX-1:0], "R2 R4 R5 R6 vector", int'(spk_vec), int'(e[NPIX-1:0]));
                check(frame_done == e[NPIX], "R7 done", int'(frame_done), int'(e[NPIX]));
            end
        end else if (rst_n) begin
            check(!frame_done && spk_vec == '0, "R3 R7 idle outputs",
                  int'({frame_done, spk_vec}), 0);
        end
    end

    // Driver: model the frame, load it, then walk the window cycle by cycle.
    task automatic run_frame(input logic [7:0] px[NPIX], input int n,
                             input bit gaps, input bit junk);
        int acc[NPIX];
        for (int p = 0; p < NPIX; p++) acc[p] = 0;
        for (int s = 1; s <= n; s++) begin
            logic [NPIX:0] e;
            e = '0;
            for (int p = 0; p < NPIX; p++) begin
                if (px[p] == 8'hFF) e[p] = 1'b1;
                else begin
                    acc[p] += px[p];
                    if (acc[p] >= 256) begin e[p] = 1'b1; acc[p] -= 256; end
                end
            end
            e[NPIX] = (s == n);
            sb_q.push_back(e);
        end
        num_steps = STEP_W'(n);
        for (int p = 0; p < NPIX; p++) begin
            pix_valid = 1'b1;
            pix_data  = px[p];
            @(posedge clk); #1;
            if (gaps && p != NPIX - 1) begin
                pix_valid = 1'b0;
                pix_data  = 8'hA5;
                @(posedge clk); #1;
            end
        end
        // Now just after the edge that took the last pixel.
        for (int k = 0; k <= n + 1; k++) begin
            if (junk && k < n) begin
                pix_valid = 1'b1;                 // R8 ignored beats
                pix_data  = 8'(37 * k + 11);
                num_steps = STEP_W'(k + 3);       // R10 ignored change
            end else begin
                pix_valid = 1'b0;
            end
            @(negedge clk);
            check(spk_valid == (k >= 1 && k <= n), "R3 R9 window timing",
                  int'(spk_valid), int'(k >= 1 && k <= n));
            @(posedge clk); #1;
        end
    endtask

    initial begin
        logic [7:0] fa[NPIX] = '{8'd0, 8'd128, 8'd255, 8'd64, 8'd1, 8'd200, 8'd127, 8'd129};
        logic [7:0] fb[NPIX] = '{8'd255, 8'd0, 8'd128, 8'd85, 8'd170, 8'd255, 8'd0, 8'd128};
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!spk_valid && !frame_done && spk_vec == '0, "R1 reset held",
              int'({spk_valid, frame_done, spk_vec}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!spk_valid && !frame_done && spk_vec == '0, "R1 after release",
              int'({spk_valid, frame_done, spk_vec}), 0);
        @(posedge clk); #1;
        run_frame(fa, 8, 1'b1, 1'b0);   // R2 R4 R5 R6 with idle gaps
        run_frame(fa, 3, 1'b0, 1'b0);   // R4 accumulators cleared per frame
        run_frame(fb, 1, 1'b0, 1'b0);   // R7 single-step window
        run_frame(fb, 10, 1'b0, 1'b1);  // R8 R10 beats and step changes ignored
        run_frame(fa, 0, 1'b0, 1'b0);   // R9 empty window
        run_frame(fb, 5, 1'b1, 1'b0);   // R8 R9 load restarts at pixel 0
        check(sb_q.size() == 0, "R3 all vectors seen", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule